// File: doc/BRIEF.md
# Syntax Element Binarizer

This block turns one syntax element value into the string of bins that an entropy coder consumes. A 3-bit type code picks the format. The generic formats are fixed length, truncated unary, truncated Rice and k-th order Exp-Golomb. A coefficient-level remainder format joins a truncated prefix to a fixed-length or Exp-Golomb suffix, split by a Rice parameter. Two small table formats cover partition-style and prediction-style elements.

Each result is registered as a 32-bit bin window, packed from the top bit downwards. It comes with a bin count and a parallel mask that marks every bypass-coded bin. Input and output use valid/ready handshakes. The block takes one element per cycle while the output is free or is being drained.

Top module: `se_binarizer`

## Requirements
- R1: An element is taken on a clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high exactly when no result is held or `out_ready` is high. The result is presented with `out_valid` on the following cycle. A result that is not taken stays unchanged.
- R2: The first bin sits at bit 31 of `out_bins` and later bins fill lower bits. `out_len` is between 1 and 32. Bit positions at and below 31-`out_len` are zero in both `out_bins` and `out_byp`. A `out_byp` bit of 1 marks a bypass bin.
- R3: Type 0 (fixed length) emits the low (`in_param[3:0]`+1) bits of the value, most significant first, all bypass.
- R4: Type 1 (truncated unary) uses cMax = `in_param`+1 and N = min(value, cMax). It emits N ones, then a zero only when N < cMax. All bins are regular.
- R5: Type 2 (truncated Rice) uses cap = `in_param[3:0]`+1 and q = value >> `in_rice`. If q < cap, it emits q ones, a zero, then the `in_rice` low bits of the value. Otherwise it emits cap ones only. Prefix bins are regular and suffix bins are bypass.
- R6: Type 3 (Exp-Golomb of order k = `in_rice`) starts from x = value. While x >= 2^k it emits a one, subtracts 2^k and increments k. It then emits a zero and x in k bits. All bins are bypass.
- R7: Type 4 (coefficient-level remainder) uses threshold T = 4 << `in_rice`. Below T it emits (value >> `in_rice`) ones, a zero and the `in_rice` low bits of the value. At or above T it emits four ones, then the R6 code of order `in_rice`+1 for value - T. All bins are bypass.
- R8: Type 5 maps value[1:0] as 0 to "1", 1 to "01", 2 to "001" and 3 to "000". All bins are regular.
- R9: Type 6 maps value[1:0] as 0 to "0", 1 to "10", and 2 or 3 to "11". The first bin is regular and the second is bypass.
- R10: Type 7 is coded exactly like type 0.
- R11: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Element offered |
| in_ready | output | 1 | Element can be taken |
| in_type | input | 3 | Format select |
| in_value | input | 12 | Element value |
| in_param | input | 5 | Length / cMax / cap parameter |
| in_rice | input | 3 | Rice parameter or Exp-Golomb order |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes result |
| out_bins | output | 32 | Bin string, first bin at bit 31 |
| out_byp | output | 32 | Bypass mark per bin position |
| out_len | output | 6 | Number of valid bins |

## Verification
The only state is the output holding register and its valid flag. A wrong result register shows at the ports on the cycle right after the element is accepted, as a mismatched bin, mask bit or count. A lost or spurious valid flag shows within one cycle as a disagreement between `out_valid`, `in_ready` and the handshake history. A stall that fails to hold is seen as a changed output while `out_ready` is low.

// File: rtl/se_binarizer.sv
module se_binarizer #(
  parameter int VW = 12,
  parameter int BW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_type,
  input  logic [VW-1:0] in_value,
  input  logic [4:0]    in_param,
  input  logic [2:0]    in_rice,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [BW-1:0] out_bins,
  output logic [BW-1:0] out_byp,
  output logic [$clog2(BW+1)-1:0] out_len
);
  localparam int LW = $clog2(BW + 1);
  localparam int IW = $clog2(BW);

  typedef struct packed {
    logic [BW-1:0] s;
    logic [BW-1:0] m;
    logic [LW-1:0] n;
  } acc_t;

  function automatic acc_t put(acc_t a, logic [BW-1:0] f, int w, logic b);
    acc_t r;
    int p;
    r = a;
    p = int'(a.n);
    for (int i = BW - 1; i >= 0; i--) begin
      if (i < w && p < BW) begin
        r.s[IW'(BW - 1 - p)] = f[IW'(i)];
        r.m[IW'(BW - 1 - p)] = b;
        p++;
      end
    end
    r.n = LW'(p);
    return r;
  endfunction

  function automatic acc_t eg(acc_t a, int v, int k);
    acc_t r;
    int x;
    int kk;
    logic go;
    r = a;
    x = v;
    kk = k;
    go = 1'b1;
    for (int j = 0; j < VW + 1; j++) begin
      if (go) begin
        if (x >= (1 << kk)) begin
          r = put(r, '1, 1, 1'b1);
          x = x - (1 << kk);
          kk++;
        end else begin
          go = 1'b0;
        end
      end
    end
    r = put(r, '0, 1, 1'b1);
    r = put(r, BW'(x), kk, 1'b1);
    return r;
  endfunction

  acc_t nx;

  always_comb begin
    int v;
    int p;
    int r;
    int c;
    int q;
    v = int'(in_value);
    p = int'(in_param);
    r = int'(in_rice);
    nx = '0;
    case (in_type)
      3'd1: begin
        c = p + 1;
        q = (v < c) ? v : c;
        nx = put(nx, '1, q, 1'b0);
        if (q < c) nx = put(nx, '0, 1, 1'b0);
      end
      3'd2: begin
        c = (p & 15) + 1;
        q = v >> r;
        if (q < c) begin
          nx = put(nx, '1, q, 1'b0);
          nx = put(nx, '0, 1, 1'b0);
          nx = put(nx, BW'(v), r, 1'b1);
        end else begin
          nx = put(nx, '1, c, 1'b0);
        end
      end
      3'd3: nx = eg(nx, v, r);
      3'd4: begin
        c = 4 << r;
        if (v < c) begin
          nx = put(nx, '1, v >> r, 1'b1);
          nx = put(nx, '0, 1, 1'b1);
          nx = put(nx, BW'(v), r, 1'b1);
        end else begin
          nx = put(nx, '1, 4, 1'b1);
          nx = eg(nx, v - c, r + 1);
        end
      end
      3'd5: begin
        case (in_value[1:0])
          2'd0:    nx = put(nx, BW'(1), 1, 1'b0);
          2'd1:    nx = put(nx, BW'(1), 2, 1'b0);
          2'd2:    nx = put(nx, BW'(1), 3, 1'b0);
          default: nx = put(nx, '0, 3, 1'b0);
        endcase
      end
      3'd6: begin
        if (in_value[1:0] == 2'd0) begin
          nx = put(nx, '0, 1, 1'b0);
        end else begin
          nx = put(nx, '1, 1, 1'b0);
          nx = put(nx, (in_value[1:0] == 2'd1) ? '0 : '1, 1, 1'b1);
        end
      end
      default: nx = put(nx, BW'(v), (p & 15) + 1, 1'b1);
    endcase
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bins  <= '0;
      out_byp   <= '0;
      out_len   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_bins <= nx.s;
        out_byp  <= nx.m;
        out_len  <= nx.n;
      end
    end
  end

  assert_len_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len != '0 && out_len <= LW'(BW)));

  assert_pad_bins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len < LW'(BW)) |-> ((out_bins << out_len) == '0));

  assert_pad_byp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len < LW'(BW)) |-> ((out_byp << out_len) == '0));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bins) && $stable(out_byp) && $stable(out_len)));

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: tb/sim_se_binarizer.sv
module sim_se_binarizer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_type = '0;
  logic [11:0] in_value = '0;
  logic [4:0] in_param = '0;
  logic [2:0] in_rice = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [31:0] out_bins;
  logic [31:0] out_byp;
  logic [5:0] out_len;

  always #4 clk = ~clk;

  se_binarizer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_type(in_type), .in_value(in_value), .in_param(in_param), .in_rice(in_rice),
    .out_valid(out_valid), .out_ready(out_ready), .out_bins(out_bins),
    .out_byp(out_byp), .out_len(out_len)
  );

  typedef struct {
    logic [31:0] b;
    logic [31:0] m;
    int n;
    string tag;
  } exp_t;

  exp_t q[$];
  bit mb[$];
  bit mm[$];
  int total = 0;
  int bad = 0;
  bit acc;
  bit done = 0;

  function automatic void add(bit b, bit y);
    mb.push_back(b);
    mm.push_back(y);
  endfunction

  function automatic void add_eg(int v, int k);
    int x;
    int pc;
    int s;
    x = (v >> k) + 1;
    pc = 0;
    while ((x >> (pc + 1)) != 0) pc++;
    for (int i = 0; i < pc; i++) add(1, 1);
    add(0, 1);
    s = v - ((1 << k) * ((1 << pc) - 1));
    for (int i = k + pc - 1; i >= 0; i--) add(((s >> i) & 1) != 0, 1);
  endfunction

  function automatic exp_t model(int t, int v, int p, int r);
    exp_t e;
    int c;
    int n;
    int th;
    mb.delete();
    mm.delete();
    case (t)
      1: begin
        c = p + 1;
        n = (v < c) ? v : c;
        for (int i = 0; i < n; i++) add(1, 0);
        if (n < c) add(0, 0);
        e.tag = "R4";
      end
      2: begin
        c = (p & 15) + 1;
        n = v >> r;
        if (n < c) begin
          for (int i = 0; i < n; i++) add(1, 0);
          add(0, 0);
          for (int i = r - 1; i >= 0; i--) add(((v >> i) & 1) != 0, 1);
        end else begin
          for (int i = 0; i < c; i++) add(1, 0);
        end
        e.tag = "R5";
      end
      3: begin
        add_eg(v, r);
        e.tag = "R6";
      end
      4: begin
        th = 4 << r;
        if (v < th) begin
          for (int i = 0; i < (v >> r); i++) add(1, 1);
          add(0, 1);
          for (int i = r - 1; i >= 0; i--) add(((v >> i) & 1) != 0, 1);
        end else begin
          for (int i = 0; i < 4; i++) add(1, 1);
          add_eg(v - th, r + 1);
        end
        e.tag = "R7";
      end
      5: begin
        case (v & 3)
          0: add(1, 0);
          1: begin add(0, 0); add(1, 0); end
          2: begin add(0, 0); add(0, 0); add(1, 0); end
          default: begin add(0, 0); add(0, 0); add(0, 0); end
        endcase
        e.tag = "R8";
      end
      6: begin
        case (v & 3)
          0: add(0, 0);
          1: begin add(1, 0); add(0, 1); end
          default: begin add(1, 0); add(1, 1); end
        endcase
        e.tag = "R9";
      end
      default: begin
        c = (p & 15) + 1;
        for (int i = c - 1; i >= 0; i--) add(((v >> i) & 1) != 0, 1);
        e.tag = (t == 7) ? "R10" : "R3";
      end
    endcase
    e.b = '0;
    e.m = '0;
    e.n = mb.size();
    for (int i = 0; i < mb.size() && i < 32; i++) begin
      e.b[31 - i] = mb[i];
      e.m[31 - i] = mm[i];
    end
    return e;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic cyc();
    bit ev;
    #1;
    ev = (q.size() != 0);
    chk(out_valid == ev, "R1", "out_valid", longint'(out_valid), longint'(ev));
    chk(in_ready == (!ev || out_ready), "R1", "in_ready", longint'(in_ready), longint'(!ev || out_ready));
    if (out_valid && out_len == 0) chk(0, "R2", "zero length", 0, 1);
    if (out_valid && ev) begin
      chk(out_bins == q[0].b, q[0].tag, "bins", longint'(out_bins), longint'(q[0].b));
      chk(out_byp == q[0].m, q[0].tag, "bypass mask", longint'(out_byp), longint'(q[0].m));
      chk(int'(out_len) == q[0].n, q[0].tag, "length", longint'(out_len), longint'(q[0].n));
    end
    if (out_valid && out_ready && ev) void'(q.pop_front());
    acc = in_valid && in_ready;
    if (acc) q.push_back(model(int'(in_type), int'(in_value), int'(in_param), int'(in_rice)));
    @(negedge clk);
  endtask

  task automatic send(int t, int v, int p, int r, int rdy_pct);
    in_type = 3'(t);
    in_value = 12'(v);
    in_param = 5'(p);
    in_rice = 3'(r);
    in_valid = 1'b1;
    out_ready = ($urandom % 100) < rdy_pct;
    cyc();
    while (!acc) begin
      out_ready = ($urandom % 100) < rdy_pct;
      cyc();
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    out_ready = 1'b1;
    for (int i = 0; i < 3; i++) cyc();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(out_valid == 1'b0, "R11", "out_valid in reset", longint'(out_valid), 0);
      @(negedge clk);
    end
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R11", "after reset", longint'({out_valid, in_ready}), 1);
    @(negedge clk);

    // R3 fixed length widths 1 and 16
    send(0, 12'hA5B, 0, 0, 100); send(0, 12'hA5B, 15, 0, 100);
    // R4 truncated unary: zero, below, at and above cMax, cMax 32
    send(1, 0, 3, 0, 100); send(1, 2, 3, 0, 100); send(1, 4, 3, 0, 100);
    send(1, 9, 3, 0, 100); send(1, 31, 31, 0, 100); send(1, 32, 31, 0, 100);
    // R5 truncated Rice: suffix present and saturated
    send(2, 13, 4, 2, 100); send(2, 300, 2, 3, 100); send(2, 0, 0, 0, 100);
    // R6 Exp-Golomb orders 0 and 7, extremes
    send(3, 0, 0, 0, 100); send(3, 1, 0, 0, 100); send(3, 4095, 0, 0, 100);
    send(3, 4095, 0, 7, 100); send(3, 127, 0, 7, 100);
    // R7 remainder below, at and above threshold
    send(4, 3, 0, 0, 100); send(4, 4, 0, 0, 100); send(4, 63, 0, 4, 100);
    send(4, 64, 0, 4, 100); send(4, 4095, 0, 0, 100); send(4, 4095, 0, 7, 100);
    // R8, R9 table formats
    for (int v = 0; v < 4; v++) send(5, v, 0, 0, 100);
    for (int v = 0; v < 4; v++) send(6, v, 0, 0, 100);
    // R10 type 7 behaves like type 0
    send(7, 12'h3C, 7, 0, 100);
    // R1 back-pressure with stalls
    for (int i = 0; i < 40; i++) send(i % 8, i * 97, i, i % 8, 30);
    drain();
    for (int i = 0; i < 3000; i++)
      send(int'($urandom % 8), int'($urandom % 4096), int'($urandom % 32), int'($urandom % 8), 70);
    drain();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule